// File: doc/BRIEF.md
# Snapshot-Readable Edge Event Counter

This block counts edges on an external, asynchronous count input with a 16-bit counter. A host reaches it through a small byte-wide register port. The counter appears as one byte register per counter byte, and one control byte sets the edge polarity, the power gating, the write lockout and the sampling mode. The count input is synchronised before any edge is detected. The counter wraps around silently.

Reads of the counter bytes never see the live counter. They return a snapshot register, which the host refreshes by writing the self-clearing capture bit. Because of this, a multi-byte read is coherent and no events are lost while it takes place. To load a value, the host sets the lock bit, writes the bytes and clears the lock again. Counting is suspended while the lock is set.

In polled mode the input is not watched continuously. Its level is sampled once per interval of a slow tick prescaler, and a rising change between two consecutive samples counts as one event. Selecting polled mode forces rising-edge polarity and volatile operation. A supply-good input blocks counting when nonvolatile operation is selected. An oscillator-enable input must be active for polled counting.

Top module: `edge_event_counter`

## Requirements
- R1: Outside polled mode, the counter adds exactly one for each edge of the synchronised count input of the polarity chosen by control bit 0. A value of 1 selects rising edges and 0 selects falling edges. Edges of the other polarity have no effect.
- R2: The counter wraps from 16'hFFFF to 16'h0000 on the next event. It neither saturates nor raises a flag.
- R3: Register addresses are: 0 = low counter byte, 1 = high counter byte, 2 = control, 3 = reads zero. The control layout is bit 7 nonvolatile select, bit 3 capture, bit 2 write lock, bit 1 poll, bit 0 polarity, and bits 6..4 read 0. Reads of addresses 0 and 1 return the snapshot register, not the live counter.
- R4: Writing the control byte with bit 3 set copies the live counter into the snapshot. Bit 3 then reads 1 for one cycle and 0 from then on. The snapshot keeps its value until the next capture, even if events occur.
- R5: While the write lock is 1, writes to addresses 0 and 1 load that byte of the live counter, and count-input edges are ignored, including after the lock is cleared. While the lock is 0, writes to addresses 0 and 1 have no effect.
- R6: With nonvolatile select set and supply_good low, no events are counted. With nonvolatile select clear, events are counted whatever the level of supply_good.
- R7: In polled mode, the input level is sampled once every POLL_TICKS pulses of tick_slow, with the interval timer starting from zero when polled mode is entered. An event is counted only when a sample is 1 and the previous sample was 0. Input changes between samples are not seen until the next sample.
- R8: Writing control with bit 1 set stores nonvolatile select as 0 and polarity as 1, whatever the written bits 7 and 0 are.
- R9: In polled mode with osc_en low, the interval timer holds and nothing is counted. Sampling resumes when osc_en returns high.
- R10: A synchronous active-high reset clears the counter, the snapshot and all control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 1 | Asynchronous count input |
| tick_slow | input | 1 | One-cycle strobe at the slow (32.768 kHz) tick rate |
| osc_en | input | 1 | Oscillator enabled; required for polled counting |
| supply_good | input | 1 | Main supply above trip point |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |

## Verification
The hardest situation to reach from the ports is the polled-mode timing. The timer is internal and its phase is hidden, and a level change counts only at the next sample. To get there, the bench uses a short interval and a periodic tick. It enters polled mode so that the timer starts from a known zero and checks that a rising level is not counted before a full interval has passed, but is counted after it. It then stops the oscillator, toggles the input across a long stretch in which nothing may be counted, and re-enables the oscillator to see the pending level counted.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int BYTE_W = 8;

    localparam int BIT_NVS  = 7;
    localparam int BIT_CAP  = 3;
    localparam int BIT_LOCK = 2;
    localparam int BIT_POLL = 1;
    localparam int BIT_POL  = 0;

    typedef struct packed {
        logic nv_sel;
        logic capture;
        logic lock;
        logic poll;
        logic rising;
    } evc_ctrl_t;

    function automatic evc_ctrl_t decode_ctrl(input logic [BYTE_W-1:0] d);
        evc_ctrl_t c;
        c.poll    = d[BIT_POLL];
        c.nv_sel  = d[BIT_NVS] & ~d[BIT_POLL];
        c.rising  = d[BIT_POL] |  d[BIT_POLL];
        c.lock    = d[BIT_LOCK];
        c.capture = d[BIT_CAP];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] encode_ctrl(input evc_ctrl_t c);
        logic [BYTE_W-1:0] d;
        d           = '0;
        d[BIT_NVS]  = c.nv_sel;
        d[BIT_CAP]  = c.capture;
        d[BIT_LOCK] = c.lock;
        d[BIT_POLL] = c.poll;
        d[BIT_POL]  = c.rising;
        return d;
    endfunction

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic prev_level
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_level <= 1'b0;
        else     prev_level <= level;
    end

    assign level = chain[STAGES-1];

    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (prev_level == $past(level))); // R1
endmodule

// File: rtl/evc_poll_timer.sv
module evc_poll_timer #(
    parameter int POLL_TICKS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic poll_on,
    input  logic osc_en,
    input  logic tick,
    output logic sample
);
    localparam int TW = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(POLL_TICKS - 1);

    logic [TW-1:0] ticks;
    logic          advance;

    assign advance = poll_on && osc_en && tick;
    assign sample  = advance && (ticks == LAST);

    always_ff @(posedge clk) begin
        if (rst || !poll_on)  ticks <= '0;
        else if (sample)      ticks <= '0;
        else if (advance)     ticks <= ticks + 1'b1;
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        ticks <= LAST); // R7
    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (poll_on && !osc_en) |=> (ticks == $past(ticks) || !poll_on)); // R9
endmodule

// File: rtl/evc_event_sel.sv
module evc_event_sel (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic prev_level,
    input  logic poll_on,
    input  logic rising,
    input  logic sample,
    output logic event_hit
);
    logic poll_last;
    logic cont_hit;
    logic poll_hit;

    assign cont_hit  = rising ? (level && !prev_level) : (!level && prev_level);
    assign poll_hit  = sample && level && !poll_last;
    assign event_hit = poll_on ? poll_hit : cont_hit;

    always_ff @(posedge clk) begin
        if (rst)         poll_last <= 1'b0;
        else if (sample) poll_last <= level;
    end

    AST_POLL_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (poll_on && event_hit) |-> sample); // R7
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int POLL_TICKS  = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_in,
    input  logic       tick_slow,
    input  logic       osc_en,
    input  logic       supply_good,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES);

    evc_ctrl_t        ctrl;
    logic [CNT_W-1:0] count, count_nx, snap;
    logic             level, prev_level, sample, event_hit;
    logic             ctrl_wr, byte_wr, count_ok;

    evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(cnt_in),
        .level(level), .prev_level(prev_level)
    );

    evc_poll_timer #(.POLL_TICKS(POLL_TICKS)) u_timer (
        .clk(clk), .rst(rst), .poll_on(ctrl.poll), .osc_en(osc_en),
        .tick(tick_slow), .sample(sample)
    );

    evc_event_sel u_sel (
        .clk(clk), .rst(rst), .level(level), .prev_level(prev_level),
        .poll_on(ctrl.poll), .rising(ctrl.rising), .sample(sample),
        .event_hit(event_hit)
    );

    assign ctrl_wr  = reg_wr && (reg_addr == CTRL_ADDR);
    assign byte_wr  = reg_wr && ctrl.lock && (reg_addr < CTRL_ADDR);
    assign count_ok = !ctrl.lock && (!ctrl.nv_sel || supply_good)
                      && (!ctrl.poll || osc_en);

    always_comb begin
        count_nx = count;
        if (byte_wr) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (reg_addr == ADDR_W'(i))
                    count_nx[i*BYTE_W +: BYTE_W] = reg_wdata;
            end
        end else if (event_hit && count_ok) begin
            count_nx = count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            snap  <= '0;
            ctrl  <= '0;
        end else begin
            count <= count_nx;
            if (ctrl_wr) begin
                ctrl <= decode_ctrl(reg_wdata);
                if (reg_wdata[BIT_CAP]) snap <= count;
            end else begin
                ctrl.capture <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR)
            reg_rdata = encode_ctrl(ctrl);
        else if (reg_addr < CTRL_ADDR)
            reg_rdata = snap[reg_addr*BYTE_W +: BYTE_W];
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !byte_wr |=> (count == $past(count) || count == $past(count) + 1'b1)); // R1
    AST_CAP_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctrl.capture && !ctrl_wr) |=> !ctrl.capture); // R4
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(snap)); // R4
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.lock && !byte_wr) |=> $stable(count)); // R5
    AST_NV_GATE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.nv_sel && !supply_good && !byte_wr) |=> $stable(count)); // R6
    AST_POLL_FORCE: assert property (@(posedge clk) disable iff (rst)
        ctrl.poll |-> (ctrl.rising && !ctrl.nv_sel)); // R8
    AST_OSC_GATE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.poll && !osc_en && !byte_wr) |=> $stable(count)); // R9
endmodule

// File: tb/edge_event_counter_test.sv
module edge_event_counter_test;
    localparam int PT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_in = 1'b0;
    logic       tick_slow = 1'b0;
    logic       osc_en = 1'b1;
    logic       supply_good = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;

    int total = 0;
    int bad = 0;
    logic [15:0] model;

    edge_event_counter #(.POLL_TICKS(PT)) uut (
        .clk(clk), .rst(rst), .cnt_in(cnt_in), .tick_slow(tick_slow),
        .osc_en(osc_en), .supply_good(supply_good), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (3) begin @(negedge clk); tick_slow = 1'b0; end
            @(negedge clk); tick_slow = 1'b1;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic snap_read(input logic [7:0] ctrl_base, output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(2'd2, ctrl_base | 8'h08);
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic set_in(input logic v);
        @(negedge clk); cnt_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(2'd0, d); check("R10 low byte", {8'h0, d}, 16'h0);
        rd(2'd1, d); check("R10 high byte", {8'h0, d}, 16'h0);
        rd(2'd2, d); check("R10 control", {8'h0, d}, 16'h0);
        rd(2'd3, d); check("R3 unused addr", {8'h0, d}, 16'h0);
    endtask

    task automatic t_edges;
        logic [15:0] v;
        wr(2'd2, 8'h01);
        set_in(1'b1); snap_read(8'h01, v); check("R1 rising counted", v, 16'h0001);
        set_in(1'b0); snap_read(8'h01, v); check("R1 falling ignored", v, 16'h0001);
        wr(2'd2, 8'h00);
        set_in(1'b1); snap_read(8'h00, v); check("R1 rising ignored", v, 16'h0001);
        set_in(1'b0); snap_read(8'h00, v); check("R1 falling counted", v, 16'h0002);
        for (int i = 0; i < 3; i++) begin set_in(1'b1); set_in(1'b0); end
        snap_read(8'h00, v); check("R1 burst of falls", v, 16'h0005);
    endtask

    task automatic t_capture;
        logic [7:0] d;
        logic [15:0] v;
        wr(2'd2, 8'h09);
        rd(2'd2, d); check("R4 capture bit one cycle", {8'h0, d}, 16'h0009);
        @(negedge clk);
        rd(2'd2, d); check("R4 capture self clear", {8'h0, d}, 16'h0001);
        set_in(1'b1); set_in(1'b0);
        rd(2'd0, d); v[7:0] = d; rd(2'd1, d); v[15:8] = d;
        check("R3 reads show snapshot", v, 16'h0005);
        snap_read(8'h01, v); check("R4 fresh capture", v, 16'h0006);
    endtask

    task automatic t_lock;
        logic [7:0] d;
        logic [15:0] v;
        wr(2'd2, 8'h05);
        rd(2'd2, d); check("R3 control readback", {8'h0, d}, 16'h0005);
        wr(2'd0, 8'h34);
        wr(2'd1, 8'h12);
        set_in(1'b1); set_in(1'b0);
        snap_read(8'h01, v); check("R5 load and ignore edges", v, 16'h1234);
        wr(2'd0, 8'h99);
        snap_read(8'h01, v); check("R5 unlocked write ignored", v, 16'h1234);
        set_in(1'b1); set_in(1'b0);
        snap_read(8'h01, v); check("R5 counting resumes", v, 16'h1235);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        wr(2'd2, 8'h05);
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        wr(2'd2, 8'h01);
        set_in(1'b1); set_in(1'b0);
        snap_read(8'h01, v); check("R2 wrap to zero", v, 16'h0000);
    endtask

    task automatic t_supply;
        logic [15:0] v;
        wr(2'd2, 8'h81);
        supply_good = 1'b0;
        set_in(1'b1); set_in(1'b0);
        snap_read(8'h81, v); check("R6 blocked by supply", v, 16'h0000);
        supply_good = 1'b1;
        set_in(1'b1); set_in(1'b0);
        snap_read(8'h81, v); check("R6 counts with supply", v, 16'h0001);
        wr(2'd2, 8'h01);
        supply_good = 1'b0;
        set_in(1'b1); set_in(1'b0);
        snap_read(8'h01, v); check("R6 volatile ignores supply", v, 16'h0002);
        supply_good = 1'b1;
    endtask

    task automatic t_poll;
        logic [7:0] d;
        logic [15:0] v;
        wr(2'd2, 8'h80);
        wr(2'd2, 8'h82);
        rd(2'd2, d); check("R8 poll forces fields", {8'h0, d}, 16'h0003);
        @(negedge clk); cnt_in = 1'b1;
        repeat (20) @(negedge clk);
        snap_read(8'h02, v); check("R7 not before interval", v, 16'h0002);
        repeat (4 * PT + 20) @(negedge clk);
        snap_read(8'h02, v); check("R7 counted at sample", v, 16'h0003);
        repeat (8 * PT) @(negedge clk);
        snap_read(8'h02, v); check("R7 steady level no count", v, 16'h0003);
        @(negedge clk); cnt_in = 1'b0;
        repeat (4 * PT + 20) @(negedge clk);
        osc_en = 1'b0;
        repeat (4) @(negedge clk);
        cnt_in = 1'b1;
        repeat (10 * PT) @(negedge clk);
        snap_read(8'h02, v); check("R9 halted without oscillator", v, 16'h0003);
        osc_en = 1'b1;
        repeat (4 * PT + 20) @(negedge clk);
        snap_read(8'h02, v); check("R9 resumes with oscillator", v, 16'h0004);
    endtask

    task automatic t_midreset;
        logic [7:0] d;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(2'd2, d); check("R10 control after reset", {8'h0, d}, 16'h0);
        rd(2'd0, d); check("R10 snapshot after reset", {8'h0, d}, 16'h0);
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);
        begin
            logic [15:0] v;
            snap_read(8'h00, v); check("R10 counter after reset", v, 16'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_edges();
        t_capture();
        t_lock();
        t_wrap();
        t_supply();
        t_poll();
        t_midreset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule